// File: doc/BRIEF.md
# Add-and-Shift Unsigned Multiplier

This block multiplies two unsigned N-bit operands over several clock cycles with a single N-bit adder. A wide accumulator holds a carry bit, an upper half and a lower half. At the start the multiplier is placed in the lower half and the multiplicand is kept in its own register. The controller then reads the accumulator LSB once for every multiplier bit. When that bit is one it adds the multiplicand into the upper half in one cycle. It shifts the whole accumulator right in a separate cycle.

The user pulses `start` while the unit is idle, with both operands valid. Because an add costs its own cycle, the latency depends on how many one-bits the multiplier holds. The block raises `done` for a single cycle and the product is valid in that cycle. A shift counter raises a flag in the cycle that holds the final shift. That flag ends the loop after exactly N shifts.

Top module: `shift_add_mul`

## Requirements
- R1: A synchronous reset leaves `done` at 0 and `product` at 0, and the unit becomes idle.
- R2: When `start` is sampled high while idle, the operands are captured. When `done` is next high, `product` equals `multiplicand * multiplier` as an unsigned 2N-bit value.
- R3: If `start` is accepted at clock edge k, `done` is high in the cycle that follows edge k + N + P, where P is the number of one-bits in the multiplier.
- R4: `done` stays high for exactly one cycle. The unit then returns to idle and can accept a new `start` at the next edge.
- R5: A `start` that arrives while an operation is running, or in the `done` cycle, has no effect. Operand inputs that change after they are captured also have no effect.
- R6: An add and a shift never happen in the same cycle, and every add is followed directly by a shift.
- R7: Each operation performs exactly N shifts, and the cycle that holds the final shift leads directly into the `done` cycle.
- R8: A reset asserted in the middle of an operation abandons it: `done` is not raised, and the next `start` works normally.
- R9: The carry bit keeps partial sums with all-ones operands from overflowing, so the maximum product (2^N−1)^2 is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin; sampled only while idle |
| multiplicand | input | WIDTH | Unsigned multiplicand |
| multiplier | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product, valid while `done` is high |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench runs every pair of 4-bit operands. This exposes a design that fuses an add with its shift, since its `done` would arrive P cycles early. It also exposes a counter flag raised one shift too late or too early, since the product would then be off by a factor of two. All-ones operands target a missing carry bit, which would drop the top bit of the partial sum. The bench holds `start` high continuously while changing the operands, and it pulses reset during an operation. A controller that restarts outside idle, or that reads live operand inputs instead of captured ones, would then give a wrong product or a misplaced `done`.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TEST   = 2'd1,
    ST_ADD    = 2'd2,
    ST_FINISH = 2'd3
  } mulState_t;

  // strobes sent from the controller to the datapath
  typedef struct packed {
    logic load;
    logic add;
    logic shift;
  } mulStrobes_t;

endpackage

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  mulStrobes_t        strb,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               accLsb,
  output logic               lastShift,
  output logic [2*WIDTH-1:0] product
);

  localparam int ACC_W = 2 * WIDTH + 1;
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  logic [ACC_W-1:0] acc;
  logic [WIDTH-1:0] mcandReg;
  logic [CNT_W-1:0] shiftCount;
  logic [WIDTH:0]   upperSum;

  // carry and upper half together take the N+1 bit sum
  assign upperSum = {1'b0, acc[2*WIDTH-1:WIDTH]} + {1'b0, mcandReg};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      mcandReg   <= '0;
      shiftCount <= '0;
    end else if (strb.load) begin
      acc        <= {{(WIDTH + 1){1'b0}}, multiplier};
      mcandReg   <= multiplicand;
      shiftCount <= '0;
    end else if (strb.add) begin
      acc[ACC_W-1:WIDTH] <= upperSum;
    end else if (strb.shift) begin
      acc        <= {1'b0, acc[ACC_W-1:1]};
      shiftCount <= shiftCount + 1'b1;
    end
  end

  assign accLsb    = acc[0];
  assign lastShift = (shiftCount == LAST_CNT);
  assign product   = acc[2*WIDTH-1:0];

  // R2: a load leaves the carry and upper half cleared
  a_r2_load_clears_upper : assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (acc[ACC_W-1:WIDTH] == '0));

  // R9: a shift never leaves a carry sitting in the MSB
  a_r9_msb_clear_after_shift : assert property (@(posedge clk) disable iff (rst)
    strb.shift |=> !acc[ACC_W-1]);

  // R7: the counter never passes the last shift index
  a_r7_count_in_range : assert property (@(posedge clk) disable iff (rst)
    strb.shift && !lastShift |=> (shiftCount != '0));

endmodule

// File: rtl/mul_control.sv
module mul_control
  import mul_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        accLsb,
  input  logic        lastShift,
  output mulStrobes_t strb,
  output logic        done
);

  mulState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nextState = ST_TEST;
        end
      end
      ST_TEST: begin
        if (accLsb) begin
          strb.add  = 1'b1;
          nextState = ST_ADD;
        end else begin
          strb.shift = 1'b1;
          nextState  = lastShift ? ST_FINISH : ST_TEST;
        end
      end
      ST_ADD: begin
        strb.shift = 1'b1;
        nextState  = lastShift ? ST_FINISH : ST_TEST;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_FINISH);

  // R6: adds and shifts are exclusive, and an add is followed by a shift
  a_r6_add_shift_exclusive : assert property (@(posedge clk) disable iff (rst)
    !(strb.add && strb.shift));
  a_r6_add_then_shift : assert property (@(posedge clk) disable iff (rst)
    strb.add |=> strb.shift);

  // R7: the final shift leads straight into the done cycle
  a_r7_last_shift_finishes : assert property (@(posedge clk) disable iff (rst)
    strb.shift && lastShift |=> done);

  // R4: done lasts one cycle
  a_r4_done_one_cycle : assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: no load outside idle
  a_r5_load_only_idle : assert property (@(posedge clk) disable iff (rst)
    strb.load |-> $past(nextState) == ST_IDLE || $past(rst) || state == ST_IDLE);

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);

  mulStrobes_t strb;
  logic        accLsb;
  logic        lastShift;

  mul_control u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .accLsb    (accLsb),
    .lastShift (lastShift),
    .strb      (strb),
    .done      (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .accLsb       (accLsb),
    .lastShift    (lastShift),
    .product      (product)
  );

  // R1: right after reset the outputs are quiet
  a_r1_reset_quiet : assert property (@(posedge clk)
    rst |=> (!done && product == '0));

endmodule

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int compared = 0;
  int mismatched = 0;
  string curTag = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  shift_add_mul #(.WIDTH(W)) i_shift_add_mul (
    .clk(clk), .rst(rst), .start(start),
    .multiplicand(mcand), .multiplier(mplier),
    .product(product), .done(done)
  );

  // behavioural reference: 0 idle, 1 busy, 2 done cycle
  int phase = 0;
  int remaining = 0;
  int expProd = 0;

  function automatic int popCount(input int v);
    int c = 0;
    for (int i = 0; i < W; i++) c += (v >> i) & 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      phase = 0;
    end else begin
      case (phase)
        0: if (start) begin
             remaining = W + popCount(int'(mplier));
             expProd   = (int'(mcand) * int'(mplier)) & ((1 << (2 * W)) - 1);
             phase     = 1;
           end
        1: begin
             remaining--;
             if (remaining == 0) phase = 2;
           end
        default: phase = 0;
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(curTag, int'(done), (phase == 2) ? 1 : 0, "done (R3 R4)");
      if (phase == 2) check(curTag, int'(product), expProd, "product (R2)");
    end
  end

  task automatic runOp(input int a, input int b);
    @(posedge clk); #1;
    start = 1'b1; mcand = W'(a); mplier = W'(b);
    @(posedge clk); #1;
    start = 1'b0;
    // R5: scramble operands after capture
    mcand = ~W'(a); mplier = ~W'(b);
    while (phase != 0) begin @(posedge clk); #1; end
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", int'(done), 0, "done after reset");
    check("R1", int'(product), 0, "product after reset");

    curTag = "R9";
    runOp(15, 15);
    runOp(15, 1);

    curTag = "R2";
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        runOp(a, b);

    // R5: start held high with changing operands
    curTag = "R5";
    @(posedge clk); #1;
    start = 1'b1;
    for (int i = 0; i < 60; i++) begin
      mcand = W'(i * 7 + 3); mplier = W'(i * 5 + 1);
      @(posedge clk); #1;
    end
    start = 1'b0;
    while (phase != 0) begin @(posedge clk); #1; end

    // R8: reset in the middle of an operation
    curTag = "R8";
    @(posedge clk); #1;
    start = 1'b1; mcand = 4'd11; mplier = 4'd13;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R8", int'(done), 0, "done after abort");
    check("R8", int'(product), 0, "product after abort");
    runOp(9, 14);
    runOp(0, 15);

    repeat (2) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule